// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Refresh Row Counter

This block models the control side of an asynchronous-strobe dynamic memory device. It watches the active-low row strobe, column strobe and write strobe, sampled on a fast system clock. It works out what kind of access each row-strobe low period is from the order in which the strobes move. Row and column addresses arrive on one multiplexed address bus and are captured at the matching strobe edges. When the device is told to refresh on its own, an internal refresh row pointer supplies the row. A behavioural bit array stores the data, so reads, early writes and late writes can be observed at the data pins.

Each row-strobe low period ends with a one-cycle completion pulse. The pulse reports the cycle class and, for refresh classes, the row that was refreshed. The output enable of the data pin follows the read rules: it opens after a read access and closes only when the column strobe rises. A read can therefore stay visible across hidden refresh cycles. A write-and-column-before-row cycle sets a test-mode flag. A plain column-before-row refresh or a row-only refresh clears that flag.

Top module: `dramc_cycle_decoder`

## Requirements
- R1: After reset, dout_oe is 0, ref_ptr is 0, test_mode is 0 and cyc_valid is 0.
- R2: If cas_n is low and we_n is high when ras_n falls, the cycle is reported with cyc_kind 2 (column-before-row refresh). ref_row equals the value ref_ptr had when ras_n fell. ref_ptr then advances by one in the same cycle as cyc_valid, and wraps from 1023 to 0.
- R3: If cas_n and we_n are both low when ras_n falls, the cycle is reported with cyc_kind 3 (test-mode set). test_mode becomes 1, and the refresh pointer advances as in R2.
- R4: If cas_n is high when ras_n falls and never falls before ras_n rises, the cycle is reported with cyc_kind 1 (row-only refresh). ref_row equals the address present at the ras_n fall, and ref_ptr is unchanged.
- R5: If we_n is high when cas_n falls during an open row, the bit at {row, column} is read. dout_oe rises with dout holding that bit, dout_oe stays 1 until cas_n rises, and the cycle is reported with cyc_kind 4.
- R6: If we_n is low when cas_n falls during an open row, din is stored at {row, column}. dout_oe stays 0 through the cycle, and the cycle is reported with cyc_kind 5.
- R7: If we_n falls while cas_n is low after a read access, din at that we_n fall is stored at the latched {row, column}. dout keeps the previously read bit, and the cycle is reported with cyc_kind 6.
- R8: Every further cas_n fall while ras_n stays low latches a new column in the same row and performs a new access. Only one cyc_valid pulse is produced, when ras_n rises.
- R9: If cas_n is held low after a read while ras_n rises and falls again, that new cycle is a column-before-row refresh (cyc_kind 2, pointer advances). Throughout it, dout_oe and dout keep the read value.
- R10: A completed cyc_kind 2 or cyc_kind 1 cycle clears test_mode.
- R11: cyc_valid is a single-cycle pulse, produced once per ras_n rising edge that ends an open row cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit |
| dout_oe | output | 1 | Data output enable (0 means high impedance) |
| cyc_valid | output | 1 | One-cycle pulse when a row cycle completes |
| cyc_kind | output | 3 | Class of the completed cycle (1 row-only, 2 CBR, 3 test set, 4 read, 5 early write, 6 late write) |
| ref_row | output | ADDR_W | Row refreshed by the last completed refresh cycle |
| ref_ptr | output | ADDR_W | Internal refresh row pointer |
| test_mode | output | 1 | Test-mode flag |

## Verification
Directed strobe sequences cover every edge ordering against the row strobe. They are: column strobe already low with write high, column strobe and write both low, column strobe held high, column strobe falling with write high, column strobe falling with write low, and write falling after the column strobe. Each sequence has its own expected class, pointer movement and data-pin behaviour, so a mixed-up decode shows at the ports. Page-mode runs with several columns separate per-column latching from per-row latching. A hidden-refresh run, with the column strobe held across a new row strobe, shows whether the output enable is tied to the column strobe or to the row strobe. A full lap of 1024 refresh cycles exercises the pointer wrap.

// File: rtl/dramc_pkg.sv
package dramc_pkg;
  typedef enum logic [2:0] {
    CYC_NONE  = 3'd0,
    CYC_RONLY = 3'd1,
    CYC_CBR   = 3'd2,
    CYC_TSET  = 3'd3,
    CYC_READ  = 3'd4,
    CYC_EWR   = 3'd5,
    CYC_DWR   = 3'd6
  } cyc_kind_e;

  localparam int STB_RAS = 2;
  localparam int STB_CAS = 1;
  localparam int STB_WE  = 0;
  localparam int STB_W   = 3;
endpackage

// File: rtl/dramc_strobe_sampler.sv
module dramc_strobe_sampler #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins,
  output logic [W-1:0] lvl,
  output logic [W-1:0] fell,
  output logic [W-1:0] rose
);
  logic [W-1:0] cur_q;
  logic [W-1:0] prv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '1;
      prv_q <= '1;
    end else begin
      cur_q <= pins;
      prv_q <= cur_q;
    end
  end

  assign lvl = cur_q;

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign fell[i] = prv_q[i] & ~cur_q[i];
    assign rose[i] = ~prv_q[i] & cur_q[i];
  end
endmodule

// File: rtl/dramc_refcnt.sv
module dramc_refcnt #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [ROW_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/dramc_array.sv
module dramc_array #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_bit,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_bit;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_bit <= mem[rd_idx];
  end
endmodule

// File: rtl/dramc_cycle_decoder.sv
module dramc_cycle_decoder
  import dramc_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int MEM_ROW_W = 4,
  parameter int MEM_COL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  output logic              cyc_valid,
  output logic [2:0]        cyc_kind,
  output logic [ADDR_W-1:0] ref_row,
  output logic [ADDR_W-1:0] ref_ptr,
  output logic              test_mode
);
  localparam int IDX_W = MEM_ROW_W + MEM_COL_W;

  logic [STB_W-1:0] stb_lvl, stb_fell, stb_rose;
  logic [ADDR_W-1:0] addr_q;
  logic              din_q;

  dramc_strobe_sampler #(.W(STB_W)) u_smp (
    .clk  (clk),
    .rst  (rst),
    .pins ({ras_n, cas_n, we_n}),
    .lvl  (stb_lvl),
    .fell (stb_fell),
    .rose (stb_rose)
  );

  // data path sampled in step with the strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      din_q  <= 1'b0;
    end else begin
      addr_q <= addr;
      din_q  <= din;
    end
  end

  logic ras_fell, ras_rose, cas_fell, cas_rose, we_fell;
  logic cas_low, we_low;
  assign ras_fell = stb_fell[STB_RAS];
  assign ras_rose = stb_rose[STB_RAS];
  assign cas_fell = stb_fell[STB_CAS];
  assign cas_rose = stb_rose[STB_CAS];
  assign we_fell  = stb_fell[STB_WE];
  assign cas_low  = ~stb_lvl[STB_CAS];
  assign we_low   = ~stb_lvl[STB_WE];

  logic              ras_open;
  cyc_kind_e         kind_q, kind_o;
  logic [ADDR_W-1:0] row_q, col_q;
  logic              oe_q;
  logic              valid_q;
  logic [ADDR_W-1:0] ref_row_q;
  logic              tmode_q;

  logic             is_self_ref;
  logic             cas_hit, dwr_hit, ras_done, adv;
  logic             wr_en, rd_en, wr_bit;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign is_self_ref = (kind_q == CYC_CBR) || (kind_q == CYC_TSET);
  assign cas_hit  = ras_open && cas_fell && !is_self_ref;
  assign dwr_hit  = ras_open && we_fell && cas_low && !cas_fell && (kind_q == CYC_READ);
  assign ras_done = ras_open && ras_rose;
  assign adv      = ras_done && is_self_ref;

  always_comb begin
    wr_en  = 1'b0;
    rd_en  = 1'b0;
    wr_bit = din_q;
    wr_idx = {row_q[MEM_ROW_W-1:0], col_q[MEM_COL_W-1:0]};
    rd_idx = {row_q[MEM_ROW_W-1:0], addr_q[MEM_COL_W-1:0]};
    if (cas_hit) begin
      if (we_low) begin
        wr_en  = 1'b1;
        wr_idx = {row_q[MEM_ROW_W-1:0], addr_q[MEM_COL_W-1:0]};
      end else begin
        rd_en = 1'b1;
      end
    end else if (dwr_hit) begin
      wr_en = 1'b1;
    end
  end

  dramc_array #(.IDX_W(IDX_W)) u_arr (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_bit (wr_bit),
    .rd_en  (rd_en),
    .rd_idx (rd_idx),
    .rd_bit (dout)
  );

  dramc_refcnt #(.ROW_W(ADDR_W)) u_ref (
    .clk (clk),
    .rst (rst),
    .adv (adv),
    .ptr (ref_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_open  <= 1'b0;
      kind_q    <= CYC_NONE;
      kind_o    <= CYC_NONE;
      row_q     <= '0;
      col_q     <= '0;
      oe_q      <= 1'b0;
      valid_q   <= 1'b0;
      ref_row_q <= '0;
      tmode_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      // row strobe decides the class it can decide on its own
      if (ras_fell) begin
        ras_open <= 1'b1;
        if (cas_low) begin
          kind_q <= we_low ? CYC_TSET : CYC_CBR;
          row_q  <= ref_ptr;
        end else begin
          kind_q <= CYC_RONLY;
          row_q  <= addr_q;
        end
      end else if (ras_done) begin
        ras_open <= 1'b0;
        valid_q  <= 1'b1;
        kind_o   <= kind_q;
        if (kind_q == CYC_RONLY || is_self_ref) ref_row_q <= row_q;
        if (kind_q == CYC_TSET) tmode_q <= 1'b1;
        else if (kind_q == CYC_CBR || kind_q == CYC_RONLY) tmode_q <= 1'b0;
      end
      // column strobe: page-mode access inside the open row
      if (cas_hit) begin
        col_q  <= addr_q;
        kind_q <= we_low ? CYC_EWR : CYC_READ;
        oe_q   <= ~we_low;
      end else if (dwr_hit) begin
        kind_q <= CYC_DWR;
      end
      if (cas_rose) oe_q <= 1'b0;
    end
  end

  assign dout_oe   = oe_q;
  assign cyc_valid = valid_q;
  assign cyc_kind  = kind_o;
  assign ref_row   = ref_row_q;
  assign test_mode = tmode_q;
endmodule

// File: rtl/dramc_cycle_decoder_chk.sv
module dramc_cycle_decoder_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cas_n,
  input logic              dout_oe,
  input logic              cyc_valid,
  input logic [2:0]        cyc_kind,
  input logic [ADDR_W-1:0] ref_ptr,
  input logic              test_mode
);
  // R2: the pointer moves only by one
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (ref_ptr != $past(ref_ptr)) |-> (ref_ptr == $past(ref_ptr) + 1'b1));

  // R2 / R3: the pointer moves only when a self-refresh class completes
  p_ptr_cause_r2: assert property (@(posedge clk) disable iff (rst)
    (ref_ptr != $past(ref_ptr)) |-> (cyc_valid && (cyc_kind == 3'd2 || cyc_kind == 3'd3)));

  p_tset_r3: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_kind == 3'd3) |-> test_mode);

  p_ronly_ptr_r4: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && cyc_kind == 3'd1) |-> (ref_ptr == $past(ref_ptr)));

  // R5: with the column strobe high long enough the output is closed
  p_oe_cas_r5: assert property (@(posedge clk) disable iff (rst)
    (cas_n && $past(cas_n) && $past(cas_n, 2)) |-> !dout_oe);

  p_tclr_r10: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && (cyc_kind == 3'd2 || cyc_kind == 3'd1)) |-> !test_mode);

  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    cyc_valid |=> !cyc_valid);
endmodule

bind dramc_cycle_decoder dramc_cycle_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cas_n     (cas_n),
  .dout_oe   (dout_oe),
  .cyc_valid (cyc_valid),
  .cyc_kind  (cyc_kind),
  .ref_ptr   (ref_ptr),
  .test_mode (test_mode)
);

// File: tb/tb_dramc_cycle_decoder.sv
module tb_dramc_cycle_decoder;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          dout, dout_oe, cyc_valid, test_mode;
  logic [2:0]    cyc_kind;
  logic [AW-1:0] ref_row, ref_ptr;

  dramc_cycle_decoder #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
    .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .ref_row(ref_row),
    .ref_ptr(ref_ptr), .test_mode(test_mode)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, valid_cnt = 0;
  int last_kind = 0, last_ref = 0, exp_ptr = 0;
  logic pulse_prev = 1'b0;
  int   long_pulse = 0;

  always @(negedge clk) begin
    if (cyc_valid) begin
      valid_cnt++;
      last_kind = int'(cyc_kind);
      last_ref  = int'(ref_row);
    end
    if (cyc_valid && pulse_prev) long_pulse++;
    pulse_prev = cyc_valid;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(dout_oe == 1'b0, "R1 oe", int'(dout_oe), 0);
    chk(ref_ptr == '0, "R1 ptr", int'(ref_ptr), 0);
    chk(test_mode == 1'b0, "R1 tmode", int'(test_mode), 0);
    chk(cyc_valid == 1'b0, "R1 valid", int'(cyc_valid), 0);
  endtask

  task automatic self_ref(input bit we_low);
    int v0 = valid_cnt;
    int p0 = exp_ptr;
    cas_n = 1'b0; we_n = ~we_low; tick(3);
    ras_n = 1'b0; tick(3);
    ras_n = 1'b1; tick(3);
    cas_n = 1'b1; we_n = 1'b1; tick(3);
    exp_ptr = (exp_ptr + 1) % 1024;
    chk(valid_cnt == v0 + 1, "R11 one pulse", valid_cnt - v0, 1);
    chk(last_kind == (we_low ? 3 : 2), we_low ? "R3 kind" : "R2 kind", last_kind, we_low ? 3 : 2);
    chk(last_ref == p0, "R2 ref_row", last_ref, p0);
    chk(int'(ref_ptr) == exp_ptr, "R2 ptr advance", int'(ref_ptr), exp_ptr);
  endtask

  task automatic t_ronly(input int row);
    int p0 = int'(ref_ptr);
    addr = AW'(row); tick(1);
    ras_n = 1'b0; tick(3);
    addr = '0; tick(2);
    ras_n = 1'b1; tick(3);
    chk(last_kind == 1, "R4 kind", last_kind, 1);
    chk(last_ref == row, "R4 ref_row", last_ref, row);
    chk(int'(ref_ptr) == p0, "R4 ptr held", int'(ref_ptr), p0);
    chk(test_mode == 1'b0, "R10 cleared by row-only", int'(test_mode), 0);
  endtask

  task automatic t_early_write(input int row, input int col, input bit d);
    addr = AW'(row); ras_n = 1'b0; tick(3);
    addr = AW'(col); we_n = 1'b0; din = d; cas_n = 1'b0; tick(3);
    chk(dout_oe == 1'b0, "R6 oe low at access", int'(dout_oe), 0);
    cas_n = 1'b1; we_n = 1'b1; tick(3);
    chk(dout_oe == 1'b0, "R6 oe low at end", int'(dout_oe), 0);
    ras_n = 1'b1; tick(3);
    chk(last_kind == 5, "R6 kind", last_kind, 5);
  endtask

  task automatic t_read(input int row, input int col, input bit exp);
    addr = AW'(row); ras_n = 1'b0; tick(3);
    addr = AW'(col); cas_n = 1'b0; tick(3);
    chk(dout_oe == 1'b1, "R5 oe high", int'(dout_oe), 1);
    chk(dout == exp, "R5 data", int'(dout), int'(exp));
    ras_n = 1'b1; tick(3);
    chk(dout_oe == 1'b1, "R5 oe held past ras", int'(dout_oe), 1);
    cas_n = 1'b1; tick(3);
    chk(dout_oe == 1'b0, "R5 oe closes on cas", int'(dout_oe), 0);
    chk(last_kind == 4, "R5 kind", last_kind, 4);
  endtask

  task automatic t_delayed_write(input int row, input int col, input bit old_d, input bit d);
    addr = AW'(row); ras_n = 1'b0; tick(3);
    addr = AW'(col); cas_n = 1'b0; tick(3);
    din = d; we_n = 1'b0; tick(3);
    chk(dout == old_d, "R7 dout keeps old", int'(dout), int'(old_d));
    we_n = 1'b1; din = ~d; cas_n = 1'b1; tick(2);
    ras_n = 1'b1; tick(3);
    chk(last_kind == 6, "R7 kind", last_kind, 6);
    t_read(row, col, d);
  endtask

  task automatic t_page(input int row);
    int v0;
    for (int c = 0; c < 4; c++) t_early_write(row, c, c[0]);
    v0 = valid_cnt;
    addr = AW'(row); ras_n = 1'b0; tick(3);
    for (int c = 0; c < 4; c++) begin
      addr = AW'(c); cas_n = 1'b0; tick(3);
      chk(dout == c[0], "R8 page column data", int'(dout), c[0]);
      cas_n = 1'b1; tick(3);
    end
    ras_n = 1'b1; tick(3);
    chk(valid_cnt == v0 + 1, "R8 single pulse", valid_cnt - v0, 1);
  endtask

  task automatic t_hidden(input int row, input int col, input bit exp);
    int p0;
    addr = AW'(row); ras_n = 1'b0; tick(3);
    addr = AW'(col); cas_n = 1'b0; tick(3);
    ras_n = 1'b1; tick(3);
    chk(last_kind == 4, "R9 first is read", last_kind, 4);
    p0 = exp_ptr;
    ras_n = 1'b0; tick(3);
    chk(dout_oe == 1'b1 && dout == exp, "R9 data held in refresh", int'(dout), int'(exp));
    ras_n = 1'b1; tick(3);
    exp_ptr = (exp_ptr + 1) % 1024;
    chk(last_kind == 2, "R9 hidden kind", last_kind, 2);
    chk(int'(ref_ptr) == exp_ptr && last_ref == p0, "R9 pointer", int'(ref_ptr), exp_ptr);
    chk(dout_oe == 1'b1 && dout == exp, "R9 data after refresh", int'(dout), int'(exp));
    cas_n = 1'b1; tick(3);
    chk(dout_oe == 1'b0, "R9 oe closes", int'(dout_oe), 0);
  endtask

  task automatic t_test_mode();
    self_ref(1'b1);
    chk(test_mode == 1'b1, "R3 set", int'(test_mode), 1);
    self_ref(1'b0);
    chk(test_mode == 1'b0, "R10 cleared by CBR", int'(test_mode), 0);
    self_ref(1'b1);
    chk(test_mode == 1'b1, "R3 set again", int'(test_mode), 1);
    t_ronly(37);
  endtask

  task automatic t_wrap();
    while (exp_ptr != 1023) self_ref(1'b0);
    self_ref(1'b0);
    chk(ref_ptr == '0, "R2 wrap", int'(ref_ptr), 0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    t_reset();
    self_ref(1'b0);
    self_ref(1'b0);
    t_ronly(5);
    t_early_write(3, 7, 1'b1);
    t_early_write(3, 8, 1'b0);
    t_read(3, 7, 1'b1);
    t_read(3, 8, 1'b0);
    t_delayed_write(3, 7, 1'b1, 1'b0);
    t_page(9);
    t_hidden(3, 8, 1'b0);
    t_test_mode();
    t_wrap();
    chk(long_pulse == 0, "R11 pulse width", long_pulse, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule